// File: doc/BRIEF.md
# Bit-manipulation ALU

This block is the combinational datapath behind the RISC-V bit-manipulation instructions. It takes two operands and a 5-bit operation code, and it returns one result in the same cycle. The operations it covers are:

- shift-and-add;
- signed and unsigned minimum and maximum;
- logic with an inverted operand;
- rotates;
- bit counts;
- byte shuffles and width extension;
- single-bit set, clear, invert and extract;
- carry-less multiplication.

The decoder upstream places either a second register value or an immediate on operand B, so the unit sees no difference between the register form and the immediate form of an operation.

A build-time parameter chooses which instruction subsets are present. The choices are none, address/basic, address/basic/single-bit, or all four. Logic for a subset that is absent is not built. Any code that selects an absent operation, and any unassigned code, yields a result of zero. The unit does not flag illegal codes, because that is the decoder's job.

Top module: `bitmanip_alu`

## Requirements
- R1: Codes 0, 1 and 2 return (A shifted left by 1, 2 or 3) plus B, modulo 2^32.
- R2: Codes 3 and 5 return the signed minimum and the signed maximum of A and B. Codes 4 and 6 return the unsigned minimum and the unsigned maximum.
- R3: Code 7 returns A AND NOT B, code 8 returns A OR NOT B, and code 9 returns NOT (A XOR B).
- R4: Code 10 rotates A left and code 11 rotates A right. The rotate amount is B[4:0].
- R5: Codes 12, 13 and 14 return, for A, the count of leading zeros, the count of trailing zeros and the number of set bits. A zero A gives 32 for both zero counts. B has no effect.
- R6: Code 15 sets each byte of the result to 0xFF when the matching byte of A is non-zero, and to 0x00 otherwise. Code 16 reverses the byte order of A. B has no effect.
- R7: Code 17 sign-extends A[7:0], code 18 sign-extends A[15:0] and code 19 zero-extends A[15:0]. B has no effect.
- R8: Form the 64-bit carry-less product of A and B. Code 20 returns its bits 31:0, code 21 returns bits 63:32 and code 22 returns bits 62:31.
- R9: With index i = B[4:0], code 23 sets bit i of A, code 24 clears it and code 25 inverts it. Code 26 returns bit i of A in result bit 0, with every other bit zero.
- R10: Codes 27 to 31 always return zero. Codes from a subset that is not built also return zero. The subsets are:
  - address: codes 0 to 2;
  - basic: codes 3 to 19;
  - carry-less: codes 20 to 22;
  - single-bit: codes 23 to 26.

  Configuration 0 builds no subset. Configuration 1 builds address and basic. Configuration 2 adds single-bit. Configuration 3 builds all four.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand: register value, or immediate placed by the decoder |
| op_sel_i | input | 5 | Operation code, as listed in the requirements |
| result_o | output | 32 | Result, valid in the same cycle |

## Verification
The unit holds no state, so a wrong internal value shows on result_o in the same cycle as the operands that expose it. Every code is therefore compared against an independent model on each vector. The corner operands 0, all-ones, 0x80000000 and 0x7FFFFFFF are crossed with each other, and random pairs are added. These corners catch the usual faults: a signed compare treated as unsigned, a count that is wrong at zero, and a rotate or product that is off by one. Reduced configurations are built alongside the full one, so an operation that leaks out of an absent subset shows as a non-zero result at once.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    typedef enum logic [4:0] {
        BMU_SH1ADD = 5'd0,  BMU_SH2ADD = 5'd1,  BMU_SH3ADD = 5'd2,
        BMU_MIN    = 5'd3,  BMU_MINU   = 5'd4,  BMU_MAX    = 5'd5,  BMU_MAXU = 5'd6,
        BMU_ANDN   = 5'd7,  BMU_ORN    = 5'd8,  BMU_XNOR   = 5'd9,
        BMU_ROL    = 5'd10, BMU_ROR    = 5'd11,
        BMU_CLZ    = 5'd12, BMU_CTZ    = 5'd13, BMU_CPOP   = 5'd14,
        BMU_ORCB   = 5'd15, BMU_REV8   = 5'd16,
        BMU_SEXTB  = 5'd17, BMU_SEXTH  = 5'd18, BMU_ZEXTH  = 5'd19,
        BMU_CLMUL  = 5'd20, BMU_CLMULH = 5'd21, BMU_CLMULR = 5'd22,
        BMU_BSET   = 5'd23, BMU_BCLR   = 5'd24, BMU_BINV   = 5'd25, BMU_BEXT = 5'd26
    } bmu_op_e;

    typedef enum logic [1:0] {
        BMU_CFG_NONE = 2'd0,
        BMU_CFG_AB   = 2'd1,
        BMU_CFG_ABS  = 2'd2,
        BMU_CFG_ABCS = 2'd3
    } bmu_cfg_e;

endpackage

// File: rtl/bmu_arith.sv
module bmu_arith
    import bmu_pkg::*;
#(
    parameter int W      = 32,
    parameter bit EN_ADD = 1'b1,
    parameter bit EN_CMP = 1'b1
) (
    input  bmu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);

    logic s_lt, u_lt;

    always_comb begin
        s_lt = $signed(a) < $signed(b);
        u_lt = a < b;
        res  = '0;
        case (op)
            BMU_SH1ADD: if (EN_ADD) res = (a << 1) + b;
            BMU_SH2ADD: if (EN_ADD) res = (a << 2) + b;
            BMU_SH3ADD: if (EN_ADD) res = (a << 3) + b;
            BMU_MIN:    if (EN_CMP) res = s_lt ? a : b;
            BMU_MINU:   if (EN_CMP) res = u_lt ? a : b;
            BMU_MAX:    if (EN_CMP) res = s_lt ? b : a;
            BMU_MAXU:   if (EN_CMP) res = u_lt ? b : a;
            default:    res = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({op, a, b})) begin
            if (EN_CMP && op == BMU_MIN) begin
                p_min_bound_r2: assert ($signed(res) <= $signed(a) && $signed(res) <= $signed(b)
                                        && (res == a || res == b));
            end
            if (EN_CMP && op == BMU_MAXU) begin
                p_maxu_bound_r2: assert (res >= a && res >= b && (res == a || res == b));
            end
        end
    end

endmodule

// File: rtl/bmu_bitwise.sv
module bmu_bitwise
    import bmu_pkg::*;
#(
    parameter int W      = 32,
    parameter bit EN_ZBB = 1'b1,
    parameter bit EN_ZBS = 1'b1
) (
    input  bmu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);

    localparam int SHW    = $clog2(W);
    localparam int NBYTES = W / 8;

    logic [SHW-1:0] amt;
    logic [W-1:0]   onehot;
    logic [W-1:0]   orc_v, rev_v;

    always_comb begin
        amt    = b[SHW-1:0];
        onehot = {{(W-1){1'b0}}, 1'b1} << amt;
        for (int i = 0; i < NBYTES; i++) begin
            orc_v[i*8 +: 8] = (|a[i*8 +: 8]) ? 8'hFF : 8'h00;
            rev_v[i*8 +: 8] = a[(NBYTES-1-i)*8 +: 8];
        end
    end

    always_comb begin
        res = '0;
        case (op)
            BMU_ANDN:  if (EN_ZBB) res = a & ~b;
            BMU_ORN:   if (EN_ZBB) res = a | ~b;
            BMU_XNOR:  if (EN_ZBB) res = ~(a ^ b);
            BMU_ROL:   if (EN_ZBB) res = (a << amt) | (a >> (W - int'(amt)));
            BMU_ROR:   if (EN_ZBB) res = (a >> amt) | (a << (W - int'(amt)));
            BMU_ORCB:  if (EN_ZBB) res = orc_v;
            BMU_REV8:  if (EN_ZBB) res = rev_v;
            BMU_SEXTB: if (EN_ZBB) res = {{(W-8){a[7]}}, a[7:0]};
            BMU_SEXTH: if (EN_ZBB) res = {{(W-16){a[15]}}, a[15:0]};
            BMU_ZEXTH: if (EN_ZBB) res = {{(W-16){1'b0}}, a[15:0]};
            BMU_BSET:  if (EN_ZBS) res = a | onehot;
            BMU_BCLR:  if (EN_ZBS) res = a & ~onehot;
            BMU_BINV:  if (EN_ZBS) res = a ^ onehot;
            BMU_BEXT:  if (EN_ZBS) res = {{(W-1){1'b0}}, a[amt]};
            default:   res = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({op, a, b})) begin
            if (EN_ZBS && op == BMU_BEXT) begin
                p_bext_upper_r9: assert (res[W-1:1] == '0);
            end
            if (EN_ZBS && op == BMU_BSET) begin
                p_bset_single_r9: assert (res[amt] && $countones(res ^ a) <= 1);
            end
            if (EN_ZBB && op == BMU_ROL) begin
                p_rol_popcount_r4: assert ($countones(res) == $countones(a));
            end
        end
    end

endmodule

// File: rtl/bmu_count.sv
module bmu_count
    import bmu_pkg::*;
#(
    parameter int W = 32
) (
    input  bmu_op_e      op,
    input  logic [W-1:0] a,
    output logic [W-1:0] res
);

    localparam int CW = $clog2(W) + 1;

    logic [CW-1:0] lead_d, trail_d, pop_d;
    logic          hit_l, hit_t;

    always_comb begin
        lead_d  = '0;
        trail_d = '0;
        pop_d   = '0;
        hit_l   = 1'b0;
        hit_t   = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (a[i]) hit_l = 1'b1;
            else if (!hit_l) lead_d = lead_d + CW'(1);
        end
        for (int i = 0; i < W; i++) begin
            if (a[i]) hit_t = 1'b1;
            else if (!hit_t) trail_d = trail_d + CW'(1);
            pop_d = pop_d + CW'(a[i]);
        end
    end

    always_comb begin
        res = '0;
        case (op)
            BMU_CLZ:  res = {{(W-CW){1'b0}}, lead_d};
            BMU_CTZ:  res = {{(W-CW){1'b0}}, trail_d};
            BMU_CPOP: res = {{(W-CW){1'b0}}, pop_d};
            default:  res = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown(a)) begin
            p_clz_zero_r5: assert ((int'(lead_d) == W) == (a == '0));
            if (int'(lead_d) < W) begin
                p_clz_first_one_r5: assert (a[W-1-int'(lead_d)]);
            end
            if (int'(trail_d) < W) begin
                p_ctz_first_one_r5: assert (a[int'(trail_d)]);
            end
        end
    end

endmodule

// File: rtl/bmu_clmul.sv
module bmu_clmul
    import bmu_pkg::*;
#(
    parameter int W = 32
) (
    input  bmu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);

    localparam int PW = 2 * W;

    logic [PW-1:0] prod_d;

    always_comb begin
        prod_d = '0;
        for (int i = 0; i < W; i++) begin
            if (b[i]) prod_d = prod_d ^ ({{W{1'b0}}, a} << i);
        end
    end

    always_comb begin
        res = '0;
        case (op)
            BMU_CLMUL:  res = prod_d[W-1:0];
            BMU_CLMULH: res = prod_d[PW-1:W];
            BMU_CLMULR: res = prod_d[PW-2:W-1];
            default:    res = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({op, a, b})) begin
            if (b == {{(W-1){1'b0}}, 1'b1} && op == BMU_CLMUL) begin
                p_clmul_identity_r8: assert (res == a);
            end
            if (b == {{(W-1){1'b0}}, 1'b1} && op == BMU_CLMULH) begin
                p_clmulh_identity_r8: assert (res == '0);
            end
        end
    end

endmodule

// File: rtl/bitmanip_alu.sv
module bitmanip_alu
    import bmu_pkg::*;
#(
    parameter int       W   = 32,
    parameter bmu_cfg_e CFG = BMU_CFG_ABCS
) (
    input  logic [W-1:0] op_a_i,
    input  logic [W-1:0] op_b_i,
    input  logic [4:0]   op_sel_i,
    output logic [W-1:0] result_o
);

    localparam bit EN_ZBA = (CFG != BMU_CFG_NONE);
    localparam bit EN_ZBB = (CFG != BMU_CFG_NONE);
    localparam bit EN_ZBS = (CFG == BMU_CFG_ABS) || (CFG == BMU_CFG_ABCS);
    localparam bit EN_ZBC = (CFG == BMU_CFG_ABCS);

    bmu_op_e      op;
    logic [W-1:0] arith_res, bitw_res, cnt_res, clm_res;

    assign op = bmu_op_e'(op_sel_i);

    bmu_arith #(.W(W), .EN_ADD(EN_ZBA), .EN_CMP(EN_ZBB)) u_arith (
        .op(op), .a(op_a_i), .b(op_b_i), .res(arith_res)
    );

    bmu_bitwise #(.W(W), .EN_ZBB(EN_ZBB), .EN_ZBS(EN_ZBS)) u_bitwise (
        .op(op), .a(op_a_i), .b(op_b_i), .res(bitw_res)
    );

    generate
        if (EN_ZBB) begin : g_count
            bmu_count #(.W(W)) u_count (.op(op), .a(op_a_i), .res(cnt_res));
        end else begin : g_no_count
            assign cnt_res = '0;
        end

        if (EN_ZBC) begin : g_clmul
            bmu_clmul #(.W(W)) u_clmul (.op(op), .a(op_a_i), .b(op_b_i), .res(clm_res));
        end else begin : g_no_clmul
            assign clm_res = '0;
        end
    endgenerate

    assign result_o = arith_res | bitw_res | cnt_res | clm_res;

    function automatic logic op_present(input logic [4:0] code);
        if (code <= 5'd2)  return EN_ZBA;
        if (code <= 5'd19) return EN_ZBB;
        if (code <= 5'd22) return EN_ZBC;
        if (code <= 5'd26) return EN_ZBS;
        return 1'b0;
    endfunction

    always_comb begin
        if (!$isunknown(op_sel_i)) begin
            if (!op_present(op_sel_i)) begin
                p_absent_zero_r10: assert (result_o == '0);
            end
        end
    end

endmodule

// File: tb/bitmanip_alu_bench.sv
module bitmanip_alu_bench;
    import bmu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic [4:0]  sel = '0;
    logic [31:0] r_full, r_abs, r_none;
    int          checks = 0;
    int          fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitmanip_alu #(.W(32), .CFG(BMU_CFG_ABCS)) u_bitmanip_alu (
        .op_a_i(a), .op_b_i(b), .op_sel_i(sel), .result_o(r_full));
    bitmanip_alu #(.W(32), .CFG(BMU_CFG_ABS)) u_bitmanip_alu_abs (
        .op_a_i(a), .op_b_i(b), .op_sel_i(sel), .result_o(r_abs));
    bitmanip_alu #(.W(32), .CFG(BMU_CFG_NONE)) u_bitmanip_alu_none (
        .op_a_i(a), .op_b_i(b), .op_sel_i(sel), .result_o(r_none));

    localparam logic [31:0] CORNERS [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000,
                                            32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_001F};

    function automatic logic built(input int op, input int cfg);
        if (op <= 19)                return cfg >= 1;
        if (op >= 20 && op <= 22)    return cfg == 3;
        if (op >= 23 && op <= 26)    return cfg >= 2;
        return 1'b0;
    endfunction

    function automatic logic [31:0] model(input int op, input logic [31:0] x, input logic [31:0] y,
                                          input int cfg);
        logic [31:0] r;
        logic [63:0] p;
        int          s;
        int          n;
        r = '0;
        s = int'(y[4:0]);
        if (!built(op, cfg)) return '0;
        case (op)
            0: r = x * 32'd2 + y;
            1: r = x * 32'd4 + y;
            2: r = x * 32'd8 + y;
            3: r = ((x ^ 32'h8000_0000) < (y ^ 32'h8000_0000)) ? x : y;
            4: r = (x < y) ? x : y;
            5: r = ((x ^ 32'h8000_0000) > (y ^ 32'h8000_0000)) ? x : y;
            6: r = (x > y) ? x : y;
            7: r = x & ~y;
            8: r = x | ~y;
            9: r = x ~^ y;
            10: for (int i = 0; i < 32; i++) r[(i + s) % 32] = x[i];
            11: for (int i = 0; i < 32; i++) r[i] = x[(i + s) % 32];
            12: begin n = 0; while (n < 32 && !x[31-n]) n++; r = n; end
            13: begin n = 0; while (n < 32 && !x[n]) n++; r = n; end
            14: for (int i = 0; i < 32; i++) r = r + {31'd0, x[i]};
            15: for (int i = 0; i < 4; i++) r[i*8 +: 8] = (x[i*8 +: 8] != 0) ? 8'hFF : 8'h00;
            16: r = {x[7:0], x[15:8], x[23:16], x[31:24]};
            17: r = 32'($signed(x[7:0]));
            18: r = 32'($signed(x[15:0]));
            19: r = {16'd0, x[15:0]};
            20, 21, 22: begin
                p = '0;
                for (int k = 0; k < 64; k++)
                    for (int i = 0; i < 32; i++)
                        if (k - i >= 0 && k - i < 32) p[k] = p[k] ^ (x[i] & y[k-i]);
                r = (op == 20) ? p[31:0] : (op == 21) ? p[63:32] : p[62:31];
            end
            23: begin r = x; r[s] = 1'b1; end
            24: begin r = x; r[s] = 1'b0; end
            25: begin r = x; r[s] = ~x[s]; end
            26: r = {31'd0, x[s]};
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic apply(input int op, input logic [31:0] x, input logic [31:0] y,
                         input string req);
        logic [31:0] e;
        @(posedge clk);
        #1;
        sel = op[4:0];
        a   = x;
        b   = y;
        @(negedge clk);
        e = model(op, x, y, 3);
        checks++;
        if (r_full !== e) begin
            fails++;
            $display("FAIL %s full op=%0d a=%h b=%h actual=%h expected=%h", req, op, x, y, r_full, e);
        end
        e = model(op, x, y, 2);
        checks++;
        if (r_abs !== e) begin
            fails++;
            $display("FAIL %s abs op=%0d a=%h b=%h actual=%h expected=%h", req, op, x, y, r_abs, e);
        end
        e = model(op, x, y, 0);
        checks++;
        if (r_none !== e) begin
            fails++;
            $display("FAIL %s none op=%0d a=%h b=%h actual=%h expected=%h", req, op, x, y, r_none, e);
        end
    endtask

    task automatic sweep(input int op, input string req);
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                apply(op, CORNERS[i], CORNERS[j], req);
        for (int k = 0; k < NRAND; k++)
            apply(op, $urandom, $urandom, req);
    endtask

    // Reset state: all-zero inputs give zero (code 0 with 0+0), R1
    task automatic t_reset_state();
        @(negedge clk);
        checks++;
        if (r_full !== 32'h0 || r_abs !== 32'h0 || r_none !== 32'h0) begin
            fails++;
            $display("FAIL R1 reset actual=%h expected=%h", r_full, 32'h0);
        end
    endtask

    task automatic t_shift_add();  for (int op = 0;  op <= 2;  op++) sweep(op, "R1"); endtask
    task automatic t_minmax();     for (int op = 3;  op <= 6;  op++) sweep(op, "R2"); endtask
    task automatic t_logic();      for (int op = 7;  op <= 9;  op++) sweep(op, "R3"); endtask
    task automatic t_rotate();
        for (int op = 10; op <= 11; op++) sweep(op, "R4");
        apply(10, 32'h8000_0001, 32'hFFFF_FFE1, "R4");   // amount 1, upper B bits ignored
        apply(11, 32'h8000_0001, 32'h0000_0020, "R4");   // amount wraps to 0
    endtask
    task automatic t_count();
        for (int op = 12; op <= 14; op++) sweep(op, "R5");
        apply(12, 32'h0, 32'hFFFF_FFFF, "R5");           // zero input gives 32
        apply(13, 32'h0, 32'h1234_5678, "R5");
    endtask
    task automatic t_bytes();      for (int op = 15; op <= 16; op++) sweep(op, "R6"); endtask
    task automatic t_extend();
        for (int op = 17; op <= 19; op++) sweep(op, "R7");
        apply(17, 32'h0000_0080, 32'hDEAD_BEEF, "R7");
        apply(18, 32'h1234_8000, 32'h0, "R7");
    endtask
    task automatic t_clmul();
        for (int op = 20; op <= 22; op++) sweep(op, "R8");
        apply(22, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
    endtask
    task automatic t_single();
        for (int op = 23; op <= 26; op++) sweep(op, "R9");
        apply(26, 32'h8000_0000, 32'h0000_003F, "R9");   // index wraps to 31
    endtask
    task automatic t_config();
        for (int op = 27; op <= 31; op++) sweep(op, "R10");
        apply(20, 32'hFFFF_FFFF, 32'h3, "R10");          // carry-less absent in reduced builds
        apply(23, 32'h0, 32'h5, "R10");                  // single-bit absent only in empty build
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_shift_add();
        t_minmax();
        t_logic();
        t_rotate();
        t_count();
        t_bytes();
        t_extend();
        t_clmul();
        t_single();
        t_config();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule